// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small byte-wide CPU. An 8-bit microaddress register selects one 16-bit word from a constant control store. The selected word is driven directly onto 16 control lines. Those lines steer the datapath's bus drivers, register loads, memory strobes and counter triggers.

Two bits of the current word feed back into the sequencer, and together they choose the next microaddress. With neither bit set, the register steps by one. The restart bit (line 5) sends it to 0, where instruction fetch begins. The dispatch bit (line 6) copies the byte on the shared data bus into the register. The opcode value is therefore the first microaddress of that instruction's routine. If both bits are set, restart wins.

The store holds five programs:

- the fetch routine at 00H–04H;
- a load-accumulator routine at 10H–14H;
- a store-accumulator routine at 20H–23H;
- a single resynchronising word at 30H, which sets both feedback bits;
- the all-rest pattern at every other address.

Top module: `mseq_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the microaddress becomes 00H. The control output then shows word 670DH.
- R2: When the current word has line 5 and line 6 both at 0, the microaddress increases by one at the next edge.
- R3: When line 5 of the current word is 1, the microaddress is 00H after the next edge.
- R4: When line 6 is 1 and line 5 is 0, the microaddress after the next edge equals the bus value sampled at that edge.
- R5: When lines 5 and 6 are both 1, as in the word at 30H (7E6DH), the microaddress goes to 00H and the bus is ignored.
- R6: Stepping from FFH yields 00H.
- R7: Addresses 00H–04H hold the fetch words 670DH, FC0DH, 670DH, 7C0DH and 7C4DH.
- R8: Addresses 10H–14H hold 7C0DH, 3F0DH, 7E0DH, 7C0FH and 7C2DH.
- R9: Addresses 20H–23H hold 7C0DH, 3F0DH, 7A0CH and 7E2DH.
- R10: Any address not listed in R1, R5, R7, R8 or R9 outputs the rest pattern 7E0DH. In this pattern lines 0, 2, 3, 9, 10, 11, 12, 13 and 14 are 1 and the rest are 0.
- R11: A rising-edge trigger line (2, 3, 11, 13) that is 0 in one word is 1 in the word that follows. The trigger therefore fires exactly one cycle after it is armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_i | input | 8 | Shared data bus; the opcode is taken from it on a dispatch |
| ctrl_o | output | 16 | Control lines, the word at the current microaddress |
| uaddr_o | output | 8 | Current microaddress |

## Verification
The control lines are a combinational lookup of the microaddress register. Both outputs therefore change only at a clock edge and can be compared against the bench model in the same cycle. A next-address decision made from the word visible in cycle k, using the bus value driven during cycle k, appears on `uaddr_o` in cycle k+1. The bench drives the bus and reset on the falling edge and compares on the following falling edge. It advances its model once per cycle from the expected word and the bus value it has just driven, so every comparison lands exactly one edge after its cause.

// File: rtl/mseq_pkg.sv
// mseq_pkg: shared widths, control-line positions and the microprogram.
// Assumes an 8-bit microaddress and a 16-bit microword; the two feedback
// bit positions are decoded by the next-address logic and must not move.
package mseq_pkg;

    localparam int UA_W = 8;
    localparam int CL_W = 16;

    // Control line positions
    localparam int L_ACC_DRV_N = 0;   // accumulator drives bus, active low
    localparam int L_ACC_LD    = 1;   // accumulator loads from bus
    localparam int L_ACC_UP    = 2;   // accumulator +1 on rising edge
    localparam int L_ACC_DN    = 3;   // accumulator -1 on rising edge
    localparam int L_RESTART   = 5;   // sequencer back to 0
    localparam int L_DISPATCH  = 6;   // sequencer loads opcode from bus
    localparam int L_MAR_LD    = 8;   // address register loads from bus
    localparam int L_MEM_RD_N  = 9;   // memory drives bus, active low
    localparam int L_MEM_WR_N  = 10;  // memory write, active low
    localparam int L_PC_UP     = 11;  // program counter +1 on rising edge
    localparam int L_PC_DRV_N  = 12;  // program counter drives bus, active low
    localparam int L_PC_DN     = 13;  // program counter -1 on rising edge
    localparam int L_IR_DRV_N  = 14;  // instruction register drives bus, active low
    localparam int L_IR_LD     = 15;  // instruction register loads from bus

    typedef logic [CL_W-1:0] uword_t;
    typedef logic [UA_W-1:0] uaddr_t;

    // Idle levels of all lines
    localparam uword_t REST = uword_t'((1 << L_ACC_DRV_N) | (1 << L_ACC_UP) | (1 << L_ACC_DN)
                                     | (1 << L_MEM_RD_N) | (1 << L_MEM_WR_N) | (1 << L_PC_UP)
                                     | (1 << L_PC_DRV_N) | (1 << L_PC_DN) | (1 << L_IR_DRV_N));

    // Returns REST with the listed lines moved to their non-idle level.
    function automatic uword_t act(input uword_t lines);
        return REST ^ lines;
    endfunction

    function automatic uword_t bit_of(input int pos);
        return uword_t'(1) << pos;
    endfunction

    // Microprogram contents for one address
    function automatic uword_t ucode_word(input uaddr_t a);
        uword_t w;
        case (a)
            // fetch: PC->MAR, mem->IR and PC+1, PC->MAR, PC+1, mem->dispatch
            8'h00: w = act(bit_of(L_PC_DRV_N) | bit_of(L_MAR_LD) | bit_of(L_PC_UP));
            8'h01: w = act(bit_of(L_MEM_RD_N) | bit_of(L_IR_LD));
            8'h02: w = act(bit_of(L_PC_DRV_N) | bit_of(L_MAR_LD) | bit_of(L_PC_UP));
            8'h03: w = act(bit_of(L_MEM_RD_N));
            8'h04: w = act(bit_of(L_MEM_RD_N) | bit_of(L_DISPATCH));
            // load accumulator from memory[operand]
            8'h10: w = act(bit_of(L_MEM_RD_N));
            8'h11: w = act(bit_of(L_IR_DRV_N) | bit_of(L_MAR_LD));
            8'h12: w = REST;
            8'h13: w = act(bit_of(L_MEM_RD_N) | bit_of(L_ACC_LD));
            8'h14: w = act(bit_of(L_MEM_RD_N) | bit_of(L_RESTART));
            // store accumulator to memory[operand]
            8'h20: w = act(bit_of(L_MEM_RD_N));
            8'h21: w = act(bit_of(L_IR_DRV_N) | bit_of(L_MAR_LD));
            8'h22: w = act(bit_of(L_ACC_DRV_N) | bit_of(L_MEM_WR_N));
            8'h23: w = act(bit_of(L_RESTART));
            // resync word: both feedback bits, restart must win
            8'h30: w = act(bit_of(L_RESTART) | bit_of(L_DISPATCH));
            default: w = REST;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/mseq_store.sv
// mseq_store: constant control store, combinational read.
// Assumes DEPTH == 2**AW; every row is built from the package microprogram.
module mseq_store
    import mseq_pkg::*;
#(
    parameter int AW = UA_W,
    parameter int CW = CL_W
) (
    input  logic [AW-1:0] addr_i,
    output logic [CW-1:0] word_o
);
    localparam int DEPTH = 1 << AW;

    logic [CW-1:0] rom [DEPTH];

    // One constant row per microaddress
    for (genvar a = 0; a < DEPTH; a++) begin : g_row
        assign rom[a] = CW'(ucode_word(UA_W'(a)));
    end

    // Read port
    assign word_o = rom[addr_i];

endmodule

// File: rtl/mseq_next.sv
// mseq_next: microaddress register with restart / dispatch / step selection.
// Assumes restart has priority over dispatch; stepping wraps modulo 2**AW.
module mseq_next #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_i,
    input  logic          dispatch_i,
    input  logic [AW-1:0] opcode_i,
    output logic [AW-1:0] uaddr_o
);
    typedef enum logic [1:0] {SEL_STEP, SEL_ZERO, SEL_OPCODE} sel_t;

    sel_t          sel;
    logic [AW-1:0] nxt;

    // Pick the next-address source, restart first
    always_comb begin
        if (restart_i)       sel = SEL_ZERO;
        else if (dispatch_i) sel = SEL_OPCODE;
        else                 sel = SEL_STEP;
    end

    // Form the next address for the chosen source
    always_comb begin
        unique case (sel)
            SEL_ZERO:   nxt = '0;
            SEL_OPCODE: nxt = opcode_i;
            default:    nxt = uaddr_o + AW'(1);
        endcase
    end

    // Microaddress register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) uaddr_o <= '0;
        else        uaddr_o <= nxt;
    end

endmodule

// File: rtl/mseq_top.sv
// mseq_top: microprogrammed control sequencer.
// The current word drives the control lines and feeds two of its bits back
// to choose the next microaddress. Assumes the opcode is stable on bus_i
// at the edge ending a dispatch word.
module mseq_top
    import mseq_pkg::*;
#(
    parameter int AW = UA_W,
    parameter int CW = CL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_i,
    output logic [CW-1:0] ctrl_o,
    output logic [AW-1:0] uaddr_o
);
    logic [AW-1:0] uaddr;
    logic [CW-1:0] word;

    mseq_next #(.AW(AW)) u_next (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart_i  (word[L_RESTART]),
        .dispatch_i (word[L_DISPATCH]),
        .opcode_i   (bus_i),
        .uaddr_o    (uaddr)
    );

    mseq_store #(.AW(AW), .CW(CW)) u_store (
        .addr_i (uaddr),
        .word_o (word)
    );

    // Drive outputs
    assign ctrl_o  = word;
    assign uaddr_o = uaddr;

endmodule

// File: rtl/mseq_chk.sv
// mseq_chk: temporal checks on the sequencer ports, bound into mseq_top.
module mseq_chk
    import mseq_pkg::*;
#(
    parameter int AW = UA_W,
    parameter int CW = CL_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_i,
    input logic [CW-1:0] ctrl_o,
    input logic [AW-1:0] uaddr_o
);
    p_reset_r1: assert property (@(posedge clk) !rst_n |=> uaddr_o == '0);

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_o[L_RESTART] && !ctrl_o[L_DISPATCH]) |=> uaddr_o == AW'($past(uaddr_o) + 1'b1));

    p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_o[L_RESTART] |=> uaddr_o == '0);

    p_dispatch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o[L_DISPATCH] && !ctrl_o[L_RESTART]) |=> uaddr_o == $past(bus_i));

    p_priority_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o[L_DISPATCH] && ctrl_o[L_RESTART]) |=> uaddr_o == '0);

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (uaddr_o >= AW'(8'h40)) |-> ctrl_o == CW'(REST));

    p_pc_fire_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_o[L_PC_UP] |=> ctrl_o[L_PC_UP]);

    p_acc_fire_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_o[L_ACC_UP] || !ctrl_o[L_ACC_DN]) |=> (ctrl_o[L_ACC_UP] && ctrl_o[L_ACC_DN]));

endmodule

bind mseq_top mseq_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_i   (bus_i),
    .ctrl_o  (ctrl_o),
    .uaddr_o (uaddr_o)
);

// File: tb/mseq_top_tb.sv
`timescale 1ns/1ps
module mseq_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus = 8'h00;
    logic [15:0] ctrl;
    logic [7:0]  uaddr;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    mseq_top u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_i   (bus),
        .ctrl_o  (ctrl),
        .uaddr_o (uaddr)
    );

    // Expected word per requirement tables R1, R5, R7..R10
    function automatic logic [15:0] exp_word(input logic [7:0] a);
        case (a)
            8'h00: return 16'h670D;
            8'h01: return 16'hFC0D;
            8'h02: return 16'h670D;
            8'h03: return 16'h7C0D;
            8'h04: return 16'h7C4D;
            8'h10: return 16'h7C0D;
            8'h11: return 16'h3F0D;
            8'h12: return 16'h7E0D;
            8'h13: return 16'h7C0F;
            8'h14: return 16'h7C2D;
            8'h20: return 16'h7C0D;
            8'h21: return 16'h3F0D;
            8'h22: return 16'h7A0C;
            8'h23: return 16'h7E2D;
            8'h30: return 16'h7E6D;
            default: return 16'h7E0D;
        endcase
    endfunction

    function automatic string word_req(input logic [7:0] a);
        if (a <= 8'h04)                 return "R7";
        if (a >= 8'h10 && a <= 8'h14)   return "R8";
        if (a >= 8'h20 && a <= 8'h23)   return "R9";
        if (a == 8'h30)                 return "R5";
        return "R10";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0]  m_addr;
        logic [15:0] m_word;
        logic [15:0] prev_ctrl;
        string       kind;
        int          loads;
        bit          was_reset;
        void'($urandom(32'd4242));
        loads = 0;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", uaddr, 8'h00);
        check("R1", ctrl, 16'h670D);
        m_addr    = 8'h00;
        kind      = "R1";
        prev_ctrl = ctrl;
        was_reset = 1;
        rst_n     = 1'b1;

        for (int cyc = 0; cyc < 4000; cyc++) begin
            m_word = exp_word(m_addr);
            // Choose the bus: directed first dispatches, then weighted random
            if (m_word[6] && !m_word[5]) begin
                loads++;
                case (loads)
                    1:       bus = 8'hFE;   // R6 wrap path
                    2:       bus = 8'h30;   // R5 priority word
                    3:       bus = 8'h10;
                    4:       bus = 8'h20;
                    default: begin
                        int r;
                        r = $urandom_range(0, 9);
                        if (r < 4)      bus = 8'h10;
                        else if (r < 7) bus = 8'h20;
                        else if (r < 8) bus = 8'h30;
                        else            bus = 8'($urandom);
                    end
                endcase
            end else begin
                bus = 8'($urandom);
            end
            // Rare random reset after the directed phase
            rst_n = !(loads > 4 && $urandom_range(0, 199) == 0);

            // Model the next address
            if (!rst_n)                     begin m_addr = 8'h00;        kind = "R1"; end
            else if (m_word[5] && m_word[6]) begin m_addr = 8'h00;       kind = "R5"; end
            else if (m_word[5])             begin m_addr = 8'h00;        kind = "R3"; end
            else if (m_word[6])             begin m_addr = bus;          kind = "R4"; end
            else begin
                kind   = (m_addr == 8'hFF) ? "R6" : "R2";
                m_addr = m_addr + 8'h01;
            end

            @(negedge clk);
            check(kind, uaddr, m_addr);
            check(word_req(m_addr), ctrl, exp_word(m_addr));
            // R11: an armed trigger line fires in the next word
            if (!was_reset && kind != "R1") begin
                if (!prev_ctrl[11]) check("R11", ctrl[11], 1'b1);
                if (!prev_ctrl[2])  check("R11", ctrl[2], 1'b1);
                if (!prev_ctrl[3])  check("R11", ctrl[3], 1'b1);
                if (!prev_ctrl[13]) check("R11", ctrl[13], 1'b1);
            end
            was_reset = (kind == "R1");
            prev_ctrl = ctrl;
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule